// File: doc/BRIEF.md
# Push-button wake and debounce controller

This block watches four active-low push-button inputs and turns recognised presses into wake events. Each event carries a 2-bit key code and is offered on a valid/ready handshake to a sequencer that runs one routine per event, or to a host that takes it as an interrupt. Raw inputs pass through a two-flop synchroniser. Each key then passes through its own debounce timer. The timer counts a reference-clock tick, and its length comes from a 2-bit field of the button configuration byte. While any key is being timed, the block asks for the reference oscillator to be held on.

Keys 1 and 2 can be merged into a two-key chord that raises the key-4 event. Events are queued in the order the keys were recognised, so several presses are served one after another. A key can be set for continuous repeat: each time its event is accepted, which marks the end of its routine, the event is raised again if the key is still down. In host mode, the interrupt output stays high while an event is pending or while a repeat-enabled key is held. The only thing modelled of the input pull-ups is their enable output.

Top module: `key_wake_ctrl`

## Requirements
- R1: The debounce length is selected by configuration bits 6:5. Code 00 gives 160 ms, 01 gives 40 ms and 10 gives 10 ms, where 1 ms is TICKS_PER_MS pulses of `ref_tick`. Code 11 recognises a press without waiting.
- R2: A key is recognised only if its input is still low when sampled at the end of its debounce interval. A press released before then raises no event.
- R3: When configuration bit 7 is set, holding keys 1 and 2 together raises a single code-3 event and no code-0 or code-1 event. Key 4 alone still raises code 3.
- R4: When bit 7 is clear, key n raises code n-1 (key 1 gives 0, key 2 gives 1, key 3 gives 2, key 4 gives 3).
- R5: Events from several keys are delivered in the order in which the keys were recognised.
- R6: Configuration bits 4, 3, 2 and 1 enable repeat for keys 4, 3, 2 and 1. The chord uses bit 4. A repeat-enabled key that is still held is queued again in the cycle its event is accepted. A key without repeat gives exactly one event per press, however long it is held.
- R7: `pullup_en` is the inverse of configuration bit 0, so it is 1 when the bit is 0.
- R8: `osc_force` is high while any key is inside its debounce interval and low otherwise.
- R9: With `host_mode` high, `irq` is high while an event is pending or a repeat-enabled key is held. With `host_mode` low, `irq` stays low.
- R10: Once `evt_valid` is high it stays high with an unchanged `evt_code` until `evt_ready` is sampled high.
- R11: After reset, `evt_valid`, `irq` and `osc_force` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_n | input | 4 | Raw active-low key inputs, bit 0 is key 1 |
| btn_cfg | input | 8 | Button configuration byte |
| host_mode | input | 1 | 1: events raise `irq` for a host |
| ref_tick | input | 1 | One-cycle pulse per reference-clock tick |
| evt_valid | output | 1 | An event is offered |
| evt_code | output | 2 | Key code of the offered event |
| evt_ready | input | 1 | Consumer accepts the event (routine done) |
| irq | output | 1 | Host interrupt request |
| osc_force | output | 1 | Request to hold the reference oscillator on |
| pullup_en | output | 1 | Enable for the input pull-ups |

## Verification
The bench times each debounce code against its window. A timer that uses the wrong code fires early or late, and one that ignores the tick fires at once. A press released mid-interval must raise nothing; a design that latches on the falling edge alone raises a spurious event. For the chord, the bench expects one code-3 event and no individual ones. A design that forgets to suppress keys 1 and 2 shows extra codes, and one that re-fires a held chord shows duplicates. The bench also checks three staggered presses for queue order, repeated events from a held repeat key with silence after its release, and a host-mode interrupt that must not drop between accepts while the key is held.

// File: rtl/key_wake_pkg.sv
package key_wake_pkg;

    // Number of physical keys and of event sources (keys plus the chord).
    localparam int NKEYS = 4;
    localparam int NSRC  = NKEYS + 1;
    localparam int SRC_W = $clog2(NSRC);

    // Index of the merged 1+2 chord source.
    localparam int SRC_CHORD = NKEYS;

    // Bit positions in the button configuration byte.
    localparam int CFG_CHORD   = 7;
    localparam int CFG_DB_HI   = 6;
    localparam int CFG_DB_LO   = 5;
    localparam int CFG_REP_LO  = 1;
    localparam int CFG_PU_DIS  = 0;

    // Debounce lengths in milliseconds, per code.
    localparam int DB_MS_00 = 160;
    localparam int DB_MS_01 = 40;
    localparam int DB_MS_10 = 10;

    typedef enum logic [1:0] {
        DB_IDLE  = 2'd0,
        DB_COUNT = 2'd1,
        DB_HELD  = 2'd2
    } db_state_t;

endpackage

// File: rtl/kw_debounce.sv
// kw_debounce: one key's debounce timer.
// Starts counting reference ticks when the synchronised key goes low, and
// samples the key once the count reaches the limit. Recognises the press only
// if the key is still low at that sample. A limit of zero recognises at once.
// Assumes key_low is already synchronised to clk and limit is stable during
// an interval.
module kw_debounce
    import key_wake_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_low,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          press_o,
    output logic          held_o,
    output logic          busy_o
);

    db_state_t     state_q;
    logic [CW-1:0] cnt_q;
    logic          press_q;

    // Debounce state machine and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
            cnt_q   <= '0;
            press_q <= 1'b0;
        end else begin
            press_q <= 1'b0;
            case (state_q)
                DB_IDLE: begin
                    if (key_low) begin
                        if (limit == '0) begin
                            state_q <= DB_HELD;
                            press_q <= 1'b1;
                        end else begin
                            state_q <= DB_COUNT;
                            cnt_q   <= '0;
                        end
                    end
                end
                DB_COUNT: begin
                    if (tick) begin
                        if (cnt_q == limit - 1'b1) begin
                            if (key_low) begin
                                state_q <= DB_HELD;
                                press_q <= 1'b1;
                            end else begin
                                state_q <= DB_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                DB_HELD: begin
                    if (!key_low) state_q <= DB_IDLE;
                end
                default: state_q <= DB_IDLE;
            endcase
        end
    end

    assign press_o = press_q;
    assign held_o  = (state_q == DB_HELD);
    assign busy_o  = (state_q == DB_COUNT);

    // R2: a press is only recognised while the key is low.
    assert_recog_only_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_o) |-> $past(key_low));

    // R1: with a nonzero limit, recognition must follow a debounce interval.
    assert_wait_before_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(held_o) && ($past(limit) != '0)) |-> $past(busy_o));

endmodule

// File: rtl/kw_event_queue.sv
// kw_event_queue: ordered queue of event source indices.
// Accepts any subset of sources in one cycle and stores them in ascending
// index order behind what is already queued. Pops the head on valid & ready.
// Assumes DEPTH is a power of two and large enough for all pending sources.
module kw_event_queue
    import key_wake_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  push,
    input  logic             pop,
    output logic             valid,
    output logic [SRC_W-1:0] head
);

    localparam int AW = $clog2(DEPTH);

    logic [SRC_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [AW:0]      cnt_q;
    logic [AW-1:0]    slot [NSRC];
    logic [AW:0]      npush;

    // Give each pushed source its own slot, in index order.
    always_comb begin
        npush = '0;
        for (int i = 0; i < NSRC; i++) begin
            slot[i] = wr_q + npush[AW-1:0];
            if (push[i]) npush = npush + 1'b1;
        end
    end

    // Store pushed sources.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (push[i]) mem_q[slot[i]] <= SRC_W'(i);
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_q + npush[AW-1:0];
            if (pop) rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + npush - {{AW{1'b0}}, pop};
        end
    end

    assign valid = (cnt_q != '0);
    assign head  = mem_q[rd_q];

    // R5: ordered storage must never lose an event to overflow.
    assert_queue_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q + npush - {{AW{1'b0}}, pop}) <= (AW+1)'(DEPTH));

endmodule

// File: rtl/key_wake_ctrl.sv
// key_wake_ctrl: push-button wake and debounce controller (top).
// Synchronises four active-low keys, debounces each against the reference
// tick, merges the optional 1+2 chord into the key-4 code, and queues events
// in recognition order on a valid/ready handshake. Acceptance of an event
// marks the end of its routine; repeat-enabled held keys are re-queued then.
// Assumes ref_tick is a single-cycle pulse synchronous to clk.
module key_wake_ctrl
    import key_wake_pkg::*;
#(
    parameter int TICKS_PER_MS = 10,
    parameter int QDEPTH       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] key_n,
    input  logic [7:0] btn_cfg,
    input  logic       host_mode,
    input  logic       ref_tick,
    output logic       evt_valid,
    output logic [1:0] evt_code,
    input  logic       evt_ready,
    output logic       irq,
    output logic       osc_force,
    output logic       pullup_en
);

    localparam int MAX_TICKS = DB_MS_00 * TICKS_PER_MS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic [NKEYS-1:0] sync1_q, sync2_q;
    logic [NKEYS-1:0] key_low, k_press, k_held, k_busy;
    logic [CW-1:0]    db_limit;
    logic             chord_en, chord_held, chord_held_q;
    logic [NSRC-1:0]  src_press, src_held, src_rep, rep_push, q_push;
    logic [SRC_W-1:0] head_src;
    logic             pop;

    // Two-flop synchroniser; released keys read as 1 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '1;
            sync2_q <= '1;
        end else begin
            sync1_q <= key_n;
            sync2_q <= sync1_q;
        end
    end

    assign key_low = ~sync2_q;

    // Decode the debounce code into a tick limit.
    always_comb begin
        case (btn_cfg[CFG_DB_HI:CFG_DB_LO])
            2'b00:   db_limit = CW'(DB_MS_00 * TICKS_PER_MS);
            2'b01:   db_limit = CW'(DB_MS_01 * TICKS_PER_MS);
            2'b10:   db_limit = CW'(DB_MS_10 * TICKS_PER_MS);
            default: db_limit = '0;
        endcase
    end

    // One debounce timer per key.
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        kw_debounce #(.CW(CW)) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .key_low (key_low[k]),
            .tick    (ref_tick),
            .limit   (db_limit),
            .press_o (k_press[k]),
            .held_o  (k_held[k]),
            .busy_o  (k_busy[k])
        );
    end

    assign chord_en   = btn_cfg[CFG_CHORD];
    assign chord_held = k_held[0] & k_held[1];

    // Remember the chord state to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) chord_held_q <= 1'b0;
        else        chord_held_q <= chord_held;
    end

    // Map keys and the chord onto event sources.
    always_comb begin
        src_press = {chord_en & chord_held & ~chord_held_q,
                     k_press[3], k_press[2],
                     k_press[1] & ~chord_en, k_press[0] & ~chord_en};
        src_held  = {chord_en & chord_held,
                     k_held[3], k_held[2],
                     k_held[1] & ~chord_en, k_held[0] & ~chord_en};
        src_rep   = {btn_cfg[CFG_REP_LO+3], btn_cfg[CFG_REP_LO+3:CFG_REP_LO]};
    end

    assign pop = evt_valid & evt_ready;

    // Re-queue the accepted source when it is held with repeat enabled.
    always_comb begin
        rep_push = '0;
        if (pop) rep_push[head_src] = src_held[head_src] & src_rep[head_src];
    end

    assign q_push = src_press | rep_push;

    kw_event_queue #(.DEPTH(QDEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .pop   (pop),
        .valid (evt_valid),
        .head  (head_src)
    );

    assign evt_code  = (head_src == SRC_W'(SRC_CHORD)) ? 2'd3 : head_src[1:0];
    assign irq       = host_mode & (evt_valid | (|(src_held & src_rep)));
    assign osc_force = |k_busy;
    assign pullup_en = ~btn_cfg[CFG_PU_DIS];

    // R10: an offered event stays put until it is accepted.
    assert_hold_until_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code)));

    // R3: with the chord enabled, keys 1 and 2 never enqueue their own codes.
    assert_chord_suppress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chord_en |-> (q_push[1:0] == 2'b00));

endmodule

// File: tb/key_wake_ctrl_tb_top.sv
module key_wake_ctrl_tb_top;

    localparam int TPM = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] key_n = 4'hF;
    logic [7:0] btn_cfg = 8'h00;
    logic       host_mode = 1'b0;
    logic       ref_tick = 1'b0;
    logic       evt_ready = 1'b0;
    logic       evt_valid, irq, osc_force, pullup_en;
    logic [1:0] evt_code;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Reference tick on every other clock.
    always @(posedge clk) ref_tick <= ~ref_tick;

    key_wake_ctrl #(.TICKS_PER_MS(TPM), .QDEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .btn_cfg(btn_cfg),
        .host_mode(host_mode), .ref_tick(ref_tick), .evt_valid(evt_valid),
        .evt_code(evt_code), .evt_ready(evt_ready), .irq(irq),
        .osc_force(osc_force), .pullup_en(pullup_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_evt(input int maxc, output bit got, output int code);
        got = 1'b0;
        code = -1;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (evt_valid) begin
                got = 1'b1;
                code = evt_code;
                break;
            end
        end
    endtask

    task automatic pop_evt();
        evt_ready = 1'b1;
        @(negedge clk);
        evt_ready = 1'b0;
    endtask

    task automatic expect_evt(input int maxc, input int exp, input string req);
        bit got;
        int code;
        wait_evt(maxc, got, code);
        chk(got && code == exp, req, "event code", code, exp);
        if (got) pop_evt();
    endtask

    task automatic expect_quiet(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (evt_valid) seen = 1'b1;
        end
        chk(!seen, req, "unexpected event", int'(seen), 0);
    endtask

    task automatic drain();
        bit got;
        int code;
        for (int i = 0; i < 4; i++) begin
            wait_evt(12, got, code);
            if (got) pop_evt();
        end
    endtask

    task automatic t_reset();
        chk(evt_valid == 0, "R11", "evt_valid after reset", evt_valid, 0);
        chk(irq == 0, "R11", "irq after reset", irq, 0);
        chk(osc_force == 0, "R11", "osc_force after reset", osc_force, 0);
        chk(pullup_en == 1, "R7", "pullup_en cfg bit0=0", pullup_en, 1);
        btn_cfg = 8'h01;
        cyc(1);
        chk(pullup_en == 0, "R7", "pullup_en cfg bit0=1", pullup_en, 0);
        btn_cfg = 8'h00;
        cyc(1);
    endtask

    task automatic t_debounce();
        bit got;
        int code;
        // Code 10: 10 ms = 20 ticks = 40 cycles.
        btn_cfg = 8'h40;
        key_n[2] = 1'b0;
        cyc(20);
        chk(evt_valid == 0, "R1", "code10 early event", evt_valid, 0);
        chk(osc_force == 1, "R8", "osc_force during debounce", osc_force, 1);
        expect_evt(40, 2, "R1 R4 key3");
        key_n[2] = 1'b1;
        cyc(6);
        chk(osc_force == 0, "R8", "osc_force after debounce", osc_force, 0);
        // Code 00: 160 ms = 640 cycles.
        btn_cfg = 8'h00;
        key_n[0] = 1'b0;
        cyc(600);
        chk(evt_valid == 0, "R1", "code00 early event", evt_valid, 0);
        expect_evt(100, 0, "R1 R4 key1");
        key_n[0] = 1'b1;
        cyc(6);
        // Code 01: 40 ms = 160 cycles.
        btn_cfg = 8'h20;
        key_n[1] = 1'b0;
        cyc(140);
        chk(evt_valid == 0, "R1", "code01 early event", evt_valid, 0);
        expect_evt(40, 1, "R1 R4 key2");
        key_n[1] = 1'b1;
        cyc(6);
        // Code 11: immediate.
        btn_cfg = 8'h60;
        key_n[3] = 1'b0;
        wait_evt(6, got, code);
        chk(got && code == 3, "R1", "code11 immediate key4", code, 3);
        if (got) pop_evt();
        key_n[3] = 1'b1;
        cyc(6);
    endtask

    task automatic t_bounce();
        btn_cfg = 8'h40;
        key_n[1] = 1'b0;
        cyc(10);
        key_n[1] = 1'b1;
        expect_quiet(80, "R2 released before sample");
        chk(osc_force == 0, "R8", "osc_force after aborted press", osc_force, 0);
    endtask

    task automatic t_chord();
        btn_cfg = 8'hE0;
        key_n[1:0] = 2'b00;
        expect_evt(8, 3, "R3 chord code");
        expect_quiet(30, "R3 chord single event");
        key_n[1:0] = 2'b11;
        cyc(6);
        key_n[3] = 1'b0;
        expect_evt(8, 3, "R3 key4 alone");
        key_n[3] = 1'b1;
        cyc(6);
    endtask

    task automatic t_order();
        btn_cfg = 8'h40;
        key_n[3] = 1'b0;
        cyc(8);
        key_n[0] = 1'b0;
        cyc(8);
        key_n[2] = 1'b0;
        cyc(80);
        expect_evt(2, 3, "R5 first");
        expect_evt(2, 0, "R5 second");
        expect_evt(2, 2, "R5 third");
        key_n = 4'hF;
        expect_quiet(20, "R5 no extra");
    endtask

    task automatic t_repeat();
        btn_cfg = 8'h64;
        key_n[1] = 1'b0;
        expect_evt(8, 1, "R6 repeat 1");
        expect_evt(4, 1, "R6 repeat 2");
        expect_evt(4, 1, "R6 repeat 3");
        key_n[1] = 1'b1;
        drain();
        expect_quiet(30, "R6 stops after release");
        key_n[2] = 1'b0;
        expect_evt(8, 2, "R6 non-repeat key");
        expect_quiet(30, "R6 held non-repeat once");
        key_n[2] = 1'b1;
        cyc(6);
    endtask

    task automatic t_irq();
        bit got;
        int code;
        host_mode = 1'b1;
        btn_cfg = 8'h62;
        key_n[0] = 1'b0;
        cyc(6);
        chk(irq == 1, "R9", "irq on press", irq, 1);
        pop_evt();
        chk(irq == 1, "R9", "irq held between accepts", irq, 1);
        pop_evt();
        chk(irq == 1, "R9", "irq still held", irq, 1);
        key_n[0] = 1'b1;
        drain();
        cyc(4);
        chk(irq == 0, "R9", "irq after release", irq, 0);
        host_mode = 1'b0;
        key_n[2] = 1'b0;
        wait_evt(8, got, code);
        chk(got && irq == 0, "R9", "irq in sequencer mode", irq, 0);
        // R10: no accept, event must stay with its code.
        cyc(5);
        chk(evt_valid == 1 && evt_code == 2, "R10", "held offer code", evt_code, 2);
        pop_evt();
        key_n[2] = 1'b1;
        cyc(6);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_debounce();
        t_bounce();
        t_chord();
        t_order();
        t_repeat();
        t_irq();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule